// File: doc/BRIEF.md
# Modem Control, Status and Loopback Unit

This unit sits beside the transmitter and receiver of a classic 16550-style serial port. It holds the modem-control register, builds the modem-status read value from the external handshake inputs, and reports changes on those inputs as sticky change flags that can raise an interrupt request. The bus decoder supplies register writes, status reads and the modem-interrupt enable bit. The transmitter's serial output and the receive pin pass through this unit.

Setting the loopback bit of the control register turns on a self-test path. The transmitter's serial stream is sent straight back into the receiver. The TX pin rests at idle, and the four modem outputs go to their inactive level. The four status inputs are then taken from the low control bits instead of from the pins. Change flags and the interrupt keep working during loopback, so software can test the whole status path without any external wiring.

Top module: `modem_loop_unit`

## Requirements
- R1: After reset, msr_o is 0, irq_o is 0, and dtr_no, rts_no, out1_no and out2_no are all 1.
- R2: With loopback off, a control write sets dtr_no, rts_no, out1_no and out2_no to the inverse of wdata_i bits 0, 1, 2 and 3. This shows from the cycle after the write.
- R3: With loopback off, tx_o equals tx_ser_i and rx_ser_o equals rx_i, combinationally.
- R4: With loopback off, msr_o[4], [5], [6] and [7] are the inverted, synchronized levels of cts_ni, dsr_ni, ri_ni and dcd_ni. A pin change shows two clock edges after it is sampled.
- R5: msr_o[0], [1] and [3] are set whenever the selected CTS, DSR or DCD status changes in either direction. For a pin, the flag shows one edge after the status bit changes.
- R6: msr_o[2] is set only when the selected RI status falls from 1 to 0. A rise of RI sets no flag.
- R7: Change flags stay set until a cycle with msr_rd_i high. They read 0 from the next cycle, unless a new change lands on that same edge. In that case the new flag wins.
- R8: irq_o is 1 exactly when ier_msi_en_i is 1 and at least one of msr_o[3:0] is 1.
- R9: While control bit 4 (loopback) is 1, tx_o and all four modem outputs are 1, rx_ser_o equals tx_ser_i, and rx_i has no effect.
- R10: While loopback is on, msr_o[7:4] equals control bits 3:0. That is CTS from DTR, DSR from RTS, RI from OUT1 and DCD from OUT2. This shows from the cycle after the write, and the external modem pins are ignored.
- R11: While loopback is on, a control write that changes bits 3:0 sets the matching change flags (RI on falling only) one edge after the new value is visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mcr_we_i | input | 1 | Modem-control register write strobe |
| wdata_i | input | 8 | Host write data |
| msr_rd_i | input | 1 | Modem-status read strobe, clears change flags |
| ier_msi_en_i | input | 1 | Modem-status interrupt enable |
| cts_ni | input | 1 | Clear-to-send pin, active low |
| dsr_ni | input | 1 | Data-set-ready pin, active low |
| dcd_ni | input | 1 | Carrier-detect pin, active low |
| ri_ni | input | 1 | Ring-indicator pin, active low |
| dtr_no | output | 1 | Data-terminal-ready pin, active low |
| rts_no | output | 1 | Request-to-send pin, active low |
| out1_no | output | 1 | General output 1, active low |
| out2_no | output | 1 | General output 2, active low |
| tx_ser_i | input | 1 | Serial output of the transmitter |
| tx_o | output | 1 | TX pin |
| rx_i | input | 1 | RX pin |
| rx_ser_o | output | 1 | Serial input to the receiver |
| msr_o | output | 8 | Modem-status read value |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
A stale previous-status register or a wrong loopback mux shows up as a change flag that is missing or extra. It appears on msr_o[3:0] one edge after the status nibble moves, and on irq_o in the same cycle. A wrong synchronizer depth shifts msr_o[7:4] by a cycle and is seen within three edges of a pin change. A wrong crossover or a wrong loopback gate shows in the cycle after the control write. The bench compares every output against a behavioural model on every cycle, so each of these faults is caught within a few cycles of its cause.

// File: rtl/mlu_pkg.sv
package mlu_pkg;
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mdm_st_t;

  localparam int MCR_W    = 5;
  localparam int LOOP_BIT = 4;
endpackage

// File: rtl/mlu_sync.sv
module mlu_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mlu_ctrl_reg.sv
module mlu_ctrl_reg #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/mlu_delta.sv
module mlu_delta
  import mlu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  mdm_st_t    cur_i,
  input  logic       rd_i,
  output logic [3:0] delta_o
);
  mdm_st_t    prev_q;
  logic [3:0] set_d;

  always_comb begin
    set_d[0] = cur_i.cts ^ prev_q.cts;
    set_d[1] = cur_i.dsr ^ prev_q.dsr;
    set_d[2] = prev_q.ri & ~cur_i.ri;   // trailing edge only
    set_d[3] = cur_i.dcd ^ prev_q.dcd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      delta_o <= '0;
    end else begin
      prev_q  <= cur_i;
      delta_o <= (rd_i ? 4'b0 : delta_o) | set_d;  // new change beats clear
    end
  end
endmodule

// File: rtl/modem_loop_unit.sv
module modem_loop_unit
  import mlu_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mcr_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          msr_rd_i,
  input  logic          ier_msi_en_i,
  input  logic          cts_ni,
  input  logic          dsr_ni,
  input  logic          dcd_ni,
  input  logic          ri_ni,
  output logic          dtr_no,
  output logic          rts_no,
  output logic          out1_no,
  output logic          out2_no,
  input  logic          tx_ser_i,
  output logic          tx_o,
  input  logic          rx_i,
  output logic          rx_ser_o,
  output logic [7:0]    msr_o,
  output logic          irq_o
);
  logic [MCR_W-1:0] mcr_q;
  logic [3:0]       pin_sync;
  logic [3:0]       delta;
  logic             loop_en;
  mdm_st_t          ext_st, loop_st, cur_st;

  mlu_ctrl_reg #(.W(MCR_W)) u_mcr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mcr_we_i),
    .wdata_i (wdata_i[MCR_W-1:0]),
    .q_o     (mcr_q)
  );

  mlu_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'hF)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({dcd_ni, ri_ni, dsr_ni, cts_ni}),
    .q_o    (pin_sync)
  );

  assign loop_en = mcr_q[LOOP_BIT];
  assign ext_st  = mdm_st_t'(~pin_sync);
  // crossover: DTR->CTS, RTS->DSR, OUT1->RI, OUT2->DCD
  assign loop_st = '{dcd: mcr_q[3], ri: mcr_q[2], dsr: mcr_q[1], cts: mcr_q[0]};
  assign cur_st  = loop_en ? loop_st : ext_st;

  mlu_delta u_delta (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cur_i   (cur_st),
    .rd_i    (msr_rd_i),
    .delta_o (delta)
  );

  assign dtr_no   = loop_en | ~mcr_q[0];
  assign rts_no   = loop_en | ~mcr_q[1];
  assign out1_no  = loop_en | ~mcr_q[2];
  assign out2_no  = loop_en | ~mcr_q[3];
  assign tx_o     = loop_en | tx_ser_i;
  assign rx_ser_o = loop_en ? tx_ser_i : rx_i;
  assign msr_o    = {cur_st, delta};
  assign irq_o    = ier_msi_en_i & (|delta);
endmodule

// File: rtl/mlu_chk.sv
module mlu_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mcr_we_i,
  input logic [7:0] wdata_i,
  input logic       msr_rd_i,
  input logic       ier_msi_en_i,
  input logic       dtr_no,
  input logic       rts_no,
  input logic       out1_no,
  input logic       out2_no,
  input logic       tx_ser_i,
  input logic       tx_o,
  input logic       rx_ser_o,
  input logic [7:0] msr_o,
  input logic       irq_o,
  input logic [4:0] mcr_i
);
  p_loop_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcr_we_i && wdata_i[4] |=> tx_o && dtr_no && rts_no && out1_no && out2_no);

  p_loop_rx_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcr_i[4] |-> rx_ser_o == tx_ser_i);

  p_drive_dtr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcr_we_i && !wdata_i[4] |=> dtr_no == !$past(wdata_i[0]) && out2_no == !$past(wdata_i[3]));

  p_cross_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcr_we_i && wdata_i[4] |=> msr_o[7:4] == $past(wdata_i[3:0]));

  p_irq_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ier_msi_en_i |-> !irq_o);

  p_irq_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_msi_en_i && (|msr_o[3:0]) |-> irq_o);

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msr_rd_i |=> (msr_o[3:0] & $past(msr_o[3:0])) == $past(msr_o[3:0]));
endmodule

bind modem_loop_unit mlu_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mcr_we_i     (mcr_we_i),
  .wdata_i      (wdata_i),
  .msr_rd_i     (msr_rd_i),
  .ier_msi_en_i (ier_msi_en_i),
  .dtr_no       (dtr_no),
  .rts_no       (rts_no),
  .out1_no      (out1_no),
  .out2_no      (out2_no),
  .tx_ser_i     (tx_ser_i),
  .tx_o         (tx_o),
  .rx_ser_o     (rx_ser_o),
  .msr_o        (msr_o),
  .irq_o        (irq_o),
  .mcr_i        (mcr_q)
);

// File: tb/sim_modem_loop_unit.sv
`timescale 1ns/1ps
module sim_modem_loop_unit;
  logic clk = 0, rst_n = 0;
  logic we = 0, rd = 0, ier = 0;
  logic [7:0] wdata = 0;
  logic cts_n = 1, dsr_n = 1, dcd_n = 1, ri_n = 1;
  logic tx_ser = 1, rx = 1;
  logic dtr_n, rts_n, out1_n, out2_n, tx, rx_ser, irq;
  logic [7:0] msr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  modem_loop_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .mcr_we_i(we), .wdata_i(wdata), .msr_rd_i(rd),
    .ier_msi_en_i(ier), .cts_ni(cts_n), .dsr_ni(dsr_n), .dcd_ni(dcd_n), .ri_ni(ri_n),
    .dtr_no(dtr_n), .rts_no(rts_n), .out1_no(out1_n), .out2_no(out2_n),
    .tx_ser_i(tx_ser), .tx_o(tx), .rx_i(rx), .rx_ser_o(rx_ser), .msr_o(msr), .irq_o(irq)
  );

  // behavioural reference: bit order [0]cts [1]dsr [2]ri [3]dcd
  bit [3:0] m_p1, m_p2, m_old, m_flag;
  bit [4:0] m_ctl;

  function automatic bit [3:0] m_stat();
    if (m_ctl[4]) return m_ctl[3:0];
    return ~m_p2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p1 = 4'hF; m_p2 = 4'hF; m_old = 0; m_flag = 0; m_ctl = 0;
    end else begin
      bit [3:0] s, nf;
      s = m_stat();
      for (int i = 0; i < 4; i++)
        nf[i] = (i == 2) ? (m_old[i] && !s[i]) : (m_old[i] != s[i]);
      if (rd) m_flag = 0;
      m_flag = m_flag | nf;
      m_old = s;
      if (we) m_ctl = wdata[4:0];
      m_p2 = m_p1;
      m_p1 = {dcd_n, ri_n, dsr_n, cts_n};
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    bit lp;
    bit [3:0] s, outs;
    lp = m_ctl[4];
    s = m_stat();
    chk(msr[7:4] == s, lp ? "R10" : "R4", msr[7:4], s);
    chk(msr[3:0] == m_flag, lp ? "R11" : "R5", msr[3:0], m_flag);
    chk(irq == (ier && |m_flag), "R8", irq, ier && |m_flag);
    outs = lp ? 4'hF : ~m_ctl[3:0];
    chk({out2_n, out1_n, rts_n, dtr_n} == outs, lp ? "R9" : "R2",
        {out2_n, out1_n, rts_n, dtr_n}, outs);
    chk(tx == (lp ? 1'b1 : tx_ser), lp ? "R9" : "R3", tx, lp ? 1'b1 : tx_ser);
    chk(rx_ser == (lp ? tx_ser : rx), lp ? "R9" : "R3", rx_ser, lp ? tx_ser : rx);
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr_ctl(input bit [7:0] v);
    we = 1; wdata = v; tick(); we = 0; wdata = 8'h00;
  endtask

  task automatic rd_stat();
    rd = 1; tick(); rd = 0;
  endtask

  task automatic wiggle(input int n);
    for (int i = 0; i < n; i++) begin
      tx_ser = i[0] ^ i[2]; rx = ~i[1]; tick();
    end
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(msr == 8'h00 && irq == 0, "R1", msr, 0);
    chk({out2_n, out1_n, rts_n, dtr_n} == 4'hF, "R1", {out2_n, out1_n, rts_n, dtr_n}, 4'hF);
    #1;
    ier = 1;
    wr_ctl(8'h05); wiggle(4);
    wr_ctl(8'hEA); wiggle(4);
    cts_n = 0; tick(); dsr_n = 0; wiggle(5);
    rd_stat(); wiggle(3);
    dcd_n = 0; cts_n = 1; wiggle(5);
    rd_stat(); tick(4);
    // R7: read clears
    rd_stat();
    @(negedge clk);
    chk(msr[3:0] == 4'h0, "R7", msr[3:0], 0);
    #1;
    // R6: RI rise no flag, fall sets flag
    ri_n = 0; tick(5);
    @(negedge clk);
    chk(msr[6] == 1 && msr[2] == 0, "R6", msr, 8'h40);
    #1;
    ri_n = 1; tick(5);
    @(negedge clk);
    chk(msr[6] == 0 && msr[2] == 1, "R6", msr, 8'h04);
    #1;
    ier = 0; wiggle(3); ier = 1;
    // read on the same edge as a new change: new flag survives
    cts_n = 0; tick(2); rd_stat(); tick(3);
    rd_stat(); tick(3);
    // loopback
    wr_ctl(8'h10); wiggle(4);
    wr_ctl(8'h1F); wiggle(3);
    cts_n = 1; dsr_n = 1; ri_n = 0; dcd_n = 1; wiggle(6);
    rd_stat(); wr_ctl(8'h13); wiggle(4);
    wr_ctl(8'h1C); rd_stat(); wiggle(4);
    for (int v = 0; v < 16; v++) begin
      wr_ctl(8'h10 | v[7:0]); wiggle(2);
      if (v[1]) rd_stat();
    end
    ri_n = 1; dcd_n = 0; wiggle(5);
    // back to normal
    wr_ctl(8'h03); wiggle(6);
    rd_stat(); wiggle(4);
    wr_ctl(8'h00); wiggle(5);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule